// File: doc/BRIEF.md
# Memory-Mapped Stall Timeout Guard

This block sits on a memory-mapped read/write path between one master and one slave. While traffic flows normally it is transparent: address, read and write strobes and write data pass straight to the slave, and read data and the slave's stall signal pass straight back to the master. A slave is allowed to stall a transfer for long stretches, for instance while a storage device erases, and the master must hold its request steady the whole time.

The guard counts consecutive cycles in which a request is outstanding and the slave is stalling. When that count reaches a limit set at run time, the guard completes the transfer itself. In that cycle it releases the stall toward the master, substitutes a fixed error word for the read data and raises a one-cycle error pulse. It then blocks the master's strobes from reaching the slave until the master drops its request. A sticky flag records that at least one timeout has happened. Setting the limit to zero turns the guard off, which leaves plain pass-through with unbounded stalls.

Top module: `mm_stall_guard`

## Requirements
- R1: With no timeout in progress and none just taken, s_read, s_write, s_address and s_writedata equal their master-side inputs, and m_waitrequest and m_readdata equal s_waitrequest and s_readdata.
- R2: With limit L ≥ 1, a request that the slave stalls continuously is shown m_waitrequest high for exactly L cycles. In the next cycle, if the slave still stalls, m_waitrequest is low, m_readdata is the error word (every byte 0xEE) and timeout_pulse is high for that single cycle.
- R3: The stall count restarts from zero after any cycle with no request or with s_waitrequest low, so a stall broken by a completed transfer does not carry over to the next request.
- R4: A limit of 0 disables the guard: no stall of any length produces timeout_pulse.
- R5: From the cycle after a timeout until the master has both read and write low for a cycle, s_read and s_write are held low and m_waitrequest is held high.
- R6: timeout_sticky becomes 1 in the cycle after a timeout pulse and stays 1 until status_clear is high at a clock edge. A timeout in the same cycle as status_clear leaves the flag set.
- R7: After reset timeout_sticky and timeout_pulse are 0 and the path is in pass-through.
- R8: Stalls of 128 cycles and longer are supported. With a limit of 200, a 150-cycle stall completes normally. With a limit of 300, the timeout fires after exactly 300 stalled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_limit | input | 16 | Stall cycles allowed before abort; 0 disables |
| status_clear | input | 1 | Clears the sticky timeout flag |
| m_address | input | 16 | Master address |
| m_read | input | 1 | Master read strobe |
| m_write | input | 1 | Master write strobe |
| m_writedata | input | 32 | Master write data |
| m_readdata | output | 32 | Read data returned to master |
| m_waitrequest | output | 1 | Stall toward master |
| s_address | output | 16 | Address to slave |
| s_read | output | 1 | Read strobe to slave |
| s_write | output | 1 | Write strobe to slave |
| s_writedata | output | 32 | Write data to slave |
| s_readdata | input | 32 | Slave read data |
| s_waitrequest | input | 1 | Slave stall |
| timeout_pulse | output | 1 | One-cycle pulse in the aborted completion cycle |
| timeout_sticky | output | 1 | Sticky timeout status |

## Verification
A stall counter that is off by one shifts the abort cycle. The bench sees this at the ports as m_waitrequest falling one cycle early or late against the exact count of L cycles. A counter that fails to restart shows up as an abort during the second of two short stalls. A drain state that clears too early or too late leaks a strobe to the slave, or holds the master stalled, in the first cycle after the abort or the first cycle after the request drops. Faults in the sticky flag are visible one cycle after the pulse or the clear.

// File: rtl/mm_guard_pkg.sv
package mm_guard_pkg;

   typedef enum logic [0:0] {
      GS_FORWARD = 1'b0,
      GS_DRAIN   = 1'b1
   } guard_state_t;

   function automatic int unsigned byte_lanes(input int unsigned width);
      return width / 8;
   endfunction

endpackage

// File: rtl/stall_counter.sv
module stall_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             stall,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic             enabled;
   logic             counting;
   logic [CNT_W-1:0] cnt_inc;

   assign enabled  = |limit;
   assign counting = req && stall;
   assign hit      = enabled && counting && (cnt >= limit);

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!counting || hit) begin
         cnt <= '0;
      end else begin
         cnt <= cnt_inc;
      end
   end

   // R3
   idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (cnt == '0));

   // R3
   release_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !stall) |=> (cnt == '0));

endmodule

// File: rtl/abort_ctrl.sv
module abort_ctrl
   import mm_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic m_req,
   output logic drain
);

   guard_state_t state, state_nxt;

   always_comb begin
      state_nxt = state;
      unique case (state)
         GS_FORWARD: if (hit)    state_nxt = GS_DRAIN;
         GS_DRAIN:   if (!m_req) state_nxt = GS_FORWARD;
         default:                state_nxt = GS_FORWARD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= GS_FORWARD;
      else        state <= state_nxt;
   end

   assign drain = (state == GS_DRAIN);

   // R5
   drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && m_req) |=> drain);

   // R5
   drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && !m_req) |=> !drain);

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R6
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);

   // R6
   sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q) |-> $past(clr));

endmodule

// File: rtl/mm_stall_guard.sv
module mm_stall_guard #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LIMIT_W  = 16,
   parameter logic [7:0]  ERR_BYTE = 8'hEE,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIMIT_W-1:0] timeout_limit,
   input  logic              status_clear,
   input  logic [ADDR_W-1:0] m_address,
   input  logic              m_read,
   input  logic              m_write,
   input  logic [DATA_W-1:0] m_writedata,
   output logic [DATA_W-1:0] m_readdata,
   output logic              m_waitrequest,
   output logic [ADDR_W-1:0] s_address,
   output logic              s_read,
   output logic              s_write,
   output logic [DATA_W-1:0] s_writedata,
   input  logic [DATA_W-1:0] s_readdata,
   input  logic              s_waitrequest,
   output logic              timeout_pulse,
   output logic              timeout_sticky
);

   import mm_guard_pkg::*;

   localparam int unsigned LANES = byte_lanes(DATA_W);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (LIMIT_W < 8 || LIMIT_W > 32) begin : g_bad_limit
         $error("LIMIT_W must lie between 8 and 32");
      end
      if (ADDR_W == 0) begin : g_bad_addr
         $error("ADDR_W must be non-zero");
      end
   endgenerate

   logic [DATA_W-1:0] err_word;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_err_lane
         assign err_word[g*8 +: 8] = ERR_BYTE;
      end
   endgenerate

   logic m_req;
   logic drain;
   logic live_req;
   logic hit;

   assign m_req    = m_read | m_write;
   assign live_req = m_req & ~drain;

   stall_counter #(
      .CNT_W    (LIMIT_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (live_req),
      .stall (s_waitrequest),
      .limit (timeout_limit),
      .hit   (hit)
   );

   abort_ctrl u_abort (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .m_req (m_req),
      .drain (drain)
   );

   sticky_flag u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (hit),
      .clr   (status_clear),
      .q     (timeout_sticky)
   );

   assign s_address     = m_address;
   assign s_writedata   = m_writedata;
   assign s_read        = m_read  & ~drain;
   assign s_write       = m_write & ~drain;
   assign m_waitrequest = drain | (s_waitrequest & ~hit);
   assign m_readdata    = hit ? err_word : s_readdata;
   assign timeout_pulse = hit;

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |=> !timeout_pulse);

   // R5
   post_abort_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |=> (!s_read && !s_write));

   // R4
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_limit == '0) |-> !timeout_pulse);

   // R2
   pulse_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> (s_waitrequest && !m_waitrequest));

endmodule

// File: tb/sim_mm_stall_guard.sv
module sim_mm_stall_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timeout_limit = 16'd5;
   logic        status_clear = 1'b0;
   logic [15:0] m_address = '0;
   logic        m_read = 1'b0;
   logic        m_write = 1'b0;
   logic [31:0] m_writedata = '0;
   logic [31:0] m_readdata;
   logic        m_waitrequest;
   logic [15:0] s_address;
   logic        s_read;
   logic        s_write;
   logic [31:0] s_writedata;
   logic [31:0] s_readdata = '0;
   logic        s_waitrequest = 1'b0;
   logic        timeout_pulse;
   logic        timeout_sticky;

   localparam logic [31:0] ERR = 32'hEEEE_EEEE;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   mm_stall_guard u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .timeout_limit  (timeout_limit),
      .status_clear   (status_clear),
      .m_address      (m_address),
      .m_read         (m_read),
      .m_write        (m_write),
      .m_writedata    (m_writedata),
      .m_readdata     (m_readdata),
      .m_waitrequest  (m_waitrequest),
      .s_address      (s_address),
      .s_read         (s_read),
      .s_write        (s_write),
      .s_writedata    (s_writedata),
      .s_readdata     (s_readdata),
      .s_waitrequest  (s_waitrequest),
      .timeout_pulse  (timeout_pulse),
      .timeout_sticky (timeout_sticky)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      m_read = 1'b0; m_write = 1'b0; s_waitrequest = 1'b0; status_clear = 1'b0;
   endtask

   // Runs a held stall from the current cycle; returns the cycle index of the
   // first timeout pulse (or -1) and whether m_waitrequest was high before it.
   task automatic stall_run(input int max, output int idx, output bit all_wait);
      idx = -1;
      all_wait = 1'b1;
      for (int i = 0; i < max; i++) begin
         if (i > 0) @(negedge clk);
         #1;
         if (timeout_pulse) begin
            idx = i;
            return;
         end
         if (!m_waitrequest) all_wait = 1'b0;
      end
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk("R7 sticky in reset", timeout_sticky, 0);
      chk("R7 pulse in reset", timeout_pulse, 0);
      @(negedge clk); rst_n = 1'b1; idle(); #1;
      chk("R7 sticky after reset", timeout_sticky, 0);
   endtask

   task automatic t_passthrough();
      timeout_limit = 16'd5;
      @(negedge clk);
      m_read = 1'b1; m_address = 16'h1234; s_waitrequest = 1'b1; s_readdata = 32'hCAFE_F00D; #1;
      chk("R1 s_read", s_read, 1);
      chk("R1 s_address", s_address, 16'h1234);
      chk("R1 wait fwd high", m_waitrequest, 1);
      @(negedge clk); s_waitrequest = 1'b0; #1;
      chk("R1 wait fwd low", m_waitrequest, 0);
      chk("R1 readdata", m_readdata, 32'hCAFE_F00D);
      @(negedge clk);
      m_read = 1'b0; m_write = 1'b1; m_writedata = 32'hA5A5_0F0F; #1;
      chk("R1 s_write", s_write, 1);
      chk("R1 s_read low", s_read, 0);
      chk("R1 s_writedata", s_writedata, 32'hA5A5_0F0F);
      @(negedge clk); idle();
   endtask

   task automatic t_timeout_read();
      int idx; bit aw;
      timeout_limit = 16'd5;
      @(negedge clk);
      m_read = 1'b1; s_waitrequest = 1'b1; s_readdata = 32'h1111_2222;
      stall_run(20, idx, aw);
      chk("R2 abort cycle L=5", idx, 5);
      chk("R2 stalled before abort", aw, 1);
      chk("R2 wait released", m_waitrequest, 0);
      chk("R2 error word", m_readdata, ERR);
      @(negedge clk); m_read = 1'b0; #1;
      chk("R2 pulse one cycle", timeout_pulse, 0);
      chk("R6 sticky set", timeout_sticky, 1);
      @(negedge clk); idle(); #1;
      chk("R6 sticky held", timeout_sticky, 1);
   endtask

   task automatic t_clear();
      int idx; bit aw;
      @(negedge clk); status_clear = 1'b1;
      @(negedge clk); status_clear = 1'b0; #1;
      chk("R6 sticky cleared", timeout_sticky, 0);
      timeout_limit = 16'd1;
      @(negedge clk); m_write = 1'b1; s_waitrequest = 1'b1;
      stall_run(5, idx, aw);
      chk("R2 abort cycle L=1", idx, 1);
      status_clear = 1'b1;
      @(negedge clk); status_clear = 1'b0; m_write = 1'b0; #1;
      chk("R6 set wins over clear", timeout_sticky, 1);
      @(negedge clk); idle(); status_clear = 1'b1;
      @(negedge clk); status_clear = 1'b0;
   endtask

   task automatic t_drain();
      int idx; bit aw;
      timeout_limit = 16'd2;
      @(negedge clk); m_read = 1'b1; s_waitrequest = 1'b1;
      stall_run(10, idx, aw);
      chk("R2 abort cycle L=2", idx, 2);
      @(negedge clk); m_address = 16'h0042; #1;
      chk("R5 read blocked", s_read, 0);
      chk("R5 master stalled", m_waitrequest, 1);
      @(negedge clk); s_waitrequest = 1'b0; #1;
      chk("R5 still blocked", s_read, 0);
      chk("R5 still stalled", m_waitrequest, 1);
      @(negedge clk); m_read = 1'b0; #1;
      chk("R5 no strobe when dropped", s_read, 0);
      @(negedge clk); m_write = 1'b1; #1;
      chk("R5 write forwarded after drain", s_write, 1);
      chk("R5 wait follows slave after drain", m_waitrequest, 0);
      @(negedge clk); idle();
   endtask

   task automatic t_restart();
      int idx; bit aw;
      timeout_limit = 16'd4;
      @(negedge clk); m_read = 1'b1; s_waitrequest = 1'b1;
      stall_run(3, idx, aw);
      chk("R3 no abort in first stall", idx, -1);
      @(negedge clk); s_waitrequest = 1'b0; #1;
      chk("R3 completion passes", m_waitrequest, 0);
      @(negedge clk); s_waitrequest = 1'b1;
      stall_run(20, idx, aw);
      chk("R3 count restarted", idx, 4);
      @(negedge clk); idle();
      @(negedge clk);
   endtask

   task automatic t_disable();
      int idx; bit aw;
      timeout_limit = 16'd0;
      @(negedge clk); m_write = 1'b1; s_waitrequest = 1'b1;
      stall_run(300, idx, aw);
      chk("R4 no abort when disabled", idx, -1);
      chk("R4 stall held throughout", aw, 1);
      @(negedge clk); s_waitrequest = 1'b0; #1;
      chk("R4 normal completion", m_waitrequest, 0);
      @(negedge clk); idle();
   endtask

   task automatic t_long();
      int idx; bit aw;
      timeout_limit = 16'd200;
      @(negedge clk); m_read = 1'b1; s_waitrequest = 1'b1; s_readdata = 32'h0BAD_F1A5;
      stall_run(150, idx, aw);
      chk("R8 no abort in 150-cycle stall", idx, -1);
      @(negedge clk); s_waitrequest = 1'b0; #1;
      chk("R8 long stall completes with slave data", m_readdata, 32'h0BAD_F1A5);
      @(negedge clk); idle();
      timeout_limit = 16'd300;
      @(negedge clk); m_read = 1'b1; s_waitrequest = 1'b1;
      stall_run(400, idx, aw);
      chk("R8 abort after 300 cycles", idx, 300);
      @(negedge clk); idle();
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_passthrough();
      t_timeout_read();
      t_clear();
      t_drain();
      t_restart();
      t_disable();
      t_long();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule